// File: doc/BRIEF.md
# Round-Robin Phase Correction Controller

This block keeps a node's local round phase as a counter that runs from zero to one less than the round length and then wraps. It advances by one on every local tick. Each round boundary brings in a signed phase correction, which the block parks in one of three correction slots. The slot is picked by the round index modulo three. A correction is not applied on arrival. It is folded into the counter only when its slot comes up for reuse, three boundaries later. Each slot therefore also serves as a settling buffer for a value that may have been produced from a marginal measurement.

At every boundary the block does two things in one step. It adds the oldest slot into the freshly wrapped counter, which makes that shift permanent. It then refills the same slot with the correction presented on the input. The block emits a one-cycle round-start pulse at each wrap. It also emits a one-cycle send strobe when the counter lands on a configured offset within the round. A correction that jumps the counter over that offset removes the strobe for that round.

Top module: `rrpc_top`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the phase becomes 0, both pulse outputs become 0, the round index becomes 0 and all three slots become zero. The first three boundaries after reset therefore apply a shift of 0.
- R2: On an edge with `tick_i` high and phase below `PERIOD-1`, the phase increases by one. On an edge with `tick_i` low, the phase holds.
- R3: `round_start_o` is high for exactly the one cycle after an edge where `tick_i` was high and the phase was `PERIOD-1`. It is low in every other cycle.
- R4: The round index advances by one modulo 3 at each boundary. The slot at the new index is applied first and then rewritten. A correction captured at boundary k is therefore applied at boundary k+3.
- R5: Corrections are two's-complement signed. At a boundary the new phase is (0 + applied correction) modulo `PERIOD`. A negative value c yields `PERIOD`+c, and -`PERIOD` yields 0.
- R6: A boundary with `corr_vld_i` low writes zero into its slot, whatever `corr_i` holds.
- R7: `send_o` is high for exactly the one cycle after a ticked edge that moves the phase onto `SEND_AT`. It fires at most once per round.
- R8: If the phase after a boundary equals `SEND_AT`, the strobe fires with the round start. If a correction moves the phase beyond `SEND_AT`, no strobe occurs in that round.
- R9: On an edge with `tick_i` low, neither pulse output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Local time increment enable |
| corr_vld_i | input | 1 | Qualifies `corr_i` at a boundary |
| corr_i | input | CORR_W | Signed phase correction sampled at a boundary |
| phase_o | output | clog2(PERIOD) | Current phase within the round |
| round_start_o | output | 1 | One-cycle pulse after each wrap |
| send_o | output | 1 | One-cycle pulse when the phase reaches `SEND_AT` |

## Verification
The bench uses several correction sequences, and each one separates a different class of fault:
- **Positive values that stay below the send offset** show whether the three-round delay and the slot rotation are right. Applying a value one round early or late moves the phase.
- **Negative values and the most negative value** exercise the modulo-`PERIOD` fold.
- **Invalid corrections carrying large data** show whether a slot is zeroed rather than loaded.
- **A correction that lands exactly on the send offset, next to one that jumps past it**, separates a strobe based on equality from one based on a threshold.
- **A correction of `PERIOD-1`** produces a boundary on the very next tick.
- **Idle gaps and a reset in the middle of a round** show that phase holds without ticks and that a reset clears slots that held non-zero values.

// File: rtl/rrpc_pkg.sv
// Shared types and arithmetic for the round-robin phase correction controller.
// Assumes corrections never exceed the round length in magnitude.
package rrpc_pkg;

    localparam int NUM_SLOTS = 3;

    typedef logic [1:0] slot_idx_t;

    // Fold base + delta back into the range [0, period).
    function automatic int wrap_add(input int base, input int delta, input int period);
        int s;
        s = base + delta;
        if (s < 0)
            s = s + period;
        else if (s >= period)
            s = s - period;
        return s;
    endfunction

    // Successor of a slot index modulo three.
    function automatic slot_idx_t slot_succ(input slot_idx_t idx);
        return (idx == slot_idx_t'(NUM_SLOTS - 1)) ? slot_idx_t'(0) : idx + 1'b1;
    endfunction

endpackage

// File: rtl/rrpc_slot_bank.sv
// Three correction slots addressed by round index modulo three.
// Presents, as rd_data_o, the slot that the next commit will reuse. That slot
// is the oldest one. On commit the round index steps forward and the same slot
// is refilled with the new correction, or with zero if it is not valid.
// Assumes commit_i is a single-cycle strobe qualified by the clock.
module rrpc_slot_bank
    import rrpc_pkg::*;
#(
    parameter int CORR_W = 5
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     commit_i,
    input  logic                     wr_vld_i,
    input  logic signed [CORR_W-1:0] wr_data_i,
    output logic signed [CORR_W-1:0] rd_data_o
);

    slot_idx_t                 idx_q;
    slot_idx_t                 idx_nxt;
    logic signed [CORR_W-1:0]  slot_q [NUM_SLOTS];
    logic signed [CORR_W-1:0]  wr_word;

    assign idx_nxt   = slot_succ(idx_q);
    assign wr_word   = wr_vld_i ? wr_data_i : '0;
    assign rd_data_o = slot_q[idx_nxt];

    // Round index register: advances once per commit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            idx_q <= '0;
        else if (commit_i)
            idx_q <= idx_nxt;
    end

    // One register per slot, rewritten only when its index comes up.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                slot_q[g] <= '0;
            else if (commit_i && (idx_nxt == slot_idx_t'(g)))
                slot_q[g] <= wr_word;
        end
    end

endmodule

// File: rtl/rrpc_phase_ctr.sv
// Modulo-PERIOD phase counter with round-start and send strobes.
// On a ticked edge at PERIOD-1 it wraps and loads shift_i folded into range.
// Otherwise a ticked edge adds one. Strobes are registered single-cycle pulses.
// Assumes |shift_i| <= PERIOD.
module rrpc_phase_ctr
    import rrpc_pkg::*;
#(
    parameter int PERIOD  = 16,
    parameter int SEND_AT = 5,
    parameter int CORR_W  = 5,
    parameter int PW      = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     tick_i,
    input  logic signed [CORR_W-1:0] shift_i,
    output logic                     boundary_o,
    output logic [PW-1:0]            phase_o,
    output logic                     round_start_o,
    output logic                     send_o
);

    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] SOFS = PW'(SEND_AT);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_d;
    logic          rs_q;
    logic          sd_q;
    logic          at_end;

    assign at_end     = (ph_q == LAST);
    assign boundary_o = tick_i && at_end;

    // Next phase: hold, step, or wrap with the retired correction folded in.
    always_comb begin
        ph_d = ph_q;
        if (tick_i) begin
            if (at_end)
                ph_d = PW'(wrap_add(0, int'(shift_i), PERIOD));
            else
                ph_d = ph_q + 1'b1;
        end
    end

    // State and strobe registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph_q <= '0;
            rs_q <= 1'b0;
            sd_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            rs_q <= boundary_o;
            sd_q <= tick_i && (ph_d == SOFS);
        end
    end

    assign phase_o       = ph_q;
    assign round_start_o = rs_q;
    assign send_o        = sd_q;

endmodule

// File: rtl/rrpc_top.sv
// Round-robin phase correction controller, top level.
// Connects the three-slot correction store to the phase counter. At each
// boundary the oldest slot is applied and then refilled in the same edge.
// Assumes |corr_i| <= PERIOD and 0 <= SEND_AT < PERIOD.
module rrpc_top #(
    parameter int PERIOD  = 16,
    parameter int SEND_AT = 5,
    parameter int CORR_W  = 5,
    parameter int PW      = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     tick_i,
    input  logic                     corr_vld_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic [PW-1:0]            phase_o,
    output logic                     round_start_o,
    output logic                     send_o
);

    logic                     boundary;
    logic signed [CORR_W-1:0] retired;

    rrpc_slot_bank #(
        .CORR_W (CORR_W)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .commit_i  (boundary),
        .wr_vld_i  (corr_vld_i),
        .wr_data_i (corr_i),
        .rd_data_o (retired)
    );

    rrpc_phase_ctr #(
        .PERIOD  (PERIOD),
        .SEND_AT (SEND_AT),
        .CORR_W  (CORR_W),
        .PW      (PW)
    ) u_ctr (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick_i),
        .shift_i       (retired),
        .boundary_o    (boundary),
        .phase_o       (phase_o),
        .round_start_o (round_start_o),
        .send_o        (send_o)
    );

endmodule

// File: rtl/rrpc_chk.sv
// Temporal checks on the controller's ports; attached by bind below.
// Assumes the same parameters as the bound instance.
module rrpc_chk #(
    parameter int PERIOD  = 16,
    parameter int SEND_AT = 5,
    parameter int PW      = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic [PW-1:0] phase_o,
    input logic          round_start_o,
    input logic          send_o
);

    logic armed_q;
    logic sent_q;

    // Marks that at least one edge has passed out of reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            armed_q <= 1'b0;
        else
            armed_q <= 1'b1;
    end

    // Remembers whether the current round has already produced a send strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            sent_q <= 1'b0;
        else if (round_start_o)
            sent_q <= send_o;
        else if (send_o)
            sent_q <= 1'b1;
    end

    p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(phase_o) < PERIOD);

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && tick_i && (int'(phase_o) != PERIOD - 1)
        |=> phase_o == PW'($past(phase_o) + 1'b1));

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && !tick_i |=> $stable(phase_o));

    p_wrap_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && tick_i && (int'(phase_o) == PERIOD - 1) |=> round_start_o);

    p_no_stray_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && !(tick_i && (int'(phase_o) == PERIOD - 1)) |=> !round_start_o);

    p_send_at_ofs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        send_o |-> int'(phase_o) == SEND_AT);

    p_send_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(send_o && !round_start_o && sent_q));

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && !tick_i |=> !send_o && !round_start_o);

endmodule

bind rrpc_top rrpc_chk #(
    .PERIOD  (PERIOD),
    .SEND_AT (SEND_AT),
    .PW      (PW)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .phase_o       (phase_o),
    .round_start_o (round_start_o),
    .send_o        (send_o)
);

// File: tb/sim_rrpc_top.sv
`timescale 1ns/1ps
module sim_rrpc_top;

    localparam int T  = 16;
    localparam int S  = 5;
    localparam int CW = 5;
    localparam int PW = 4;

    typedef struct {
        int    ph;
        logic  rs;
        logic  sd;
        string tph;
        string trs;
        string tsd;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick = 1'b0;
    logic                 vld = 1'b0;
    logic signed [CW-1:0] corr = '0;
    logic [PW-1:0]        phase;
    logic                 rs;
    logic                 sd;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    exp_t q[$];

    // Reference model state
    int    m_ph = 0;
    int    m_idx = 0;
    int    m_slot[3] = '{0, 0, 0};
    string m_stag[3] = '{"R1", "R1", "R1"};
    bit    m_bnd = 1'b0;

    always #2.5 clk = ~clk;

    rrpc_top #(.PERIOD(T), .SEND_AT(S), .CORR_W(CW), .PW(PW)) u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .corr_vld_i    (vld),
        .corr_i        (corr),
        .phase_o       (phase),
        .round_start_o (rs),
        .send_o        (sd)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
    task automatic step(input logic r, input logic tk, input logic v, input int c);
        exp_t e;
        int   n;
        @(negedge clk);
        rst_n = r; tick = tk; vld = v; corr = CW'(c);
        @(posedge clk);
        m_bnd = 1'b0;
        if (!r) begin
            m_ph = 0; m_idx = 0;
            foreach (m_slot[i]) begin m_slot[i] = 0; m_stag[i] = "R1"; end
            e = '{0, 1'b0, 1'b0, "R1", "R1", "R1"};
        end else if (!tk) begin
            e = '{m_ph, 1'b0, 1'b0, "R2", "R9", "R9"};
        end else if (m_ph == T - 1) begin
            m_bnd = 1'b1;
            m_idx = (m_idx + 1) % 3;
            n = m_slot[m_idx];
            m_ph = (n < 0) ? n + T : n;
            if (m_ph >= T) m_ph = m_ph - T;
            e = '{m_ph, 1'b1, (m_ph == S), m_stag[m_idx], "R3", "R8"};
            m_slot[m_idx] = v ? c : 0;
            m_stag[m_idx] = !v ? "R6" : (c < 0 ? "R5" : "R4");
        end else begin
            m_ph = m_ph + 1;
            e = '{m_ph, 1'b0, (m_ph == S), "R2", "R3", "R7"};
        end
        q.push_back(e);
    endtask

    // Tick until a boundary consumes (v, c); gap inserts idle cycles mid-round.
    task automatic run_round(input logic v, input int c, input int gap);
        int k = 0;
        do begin
            if (gap > 0 && k == 7) repeat (gap) step(1'b1, 1'b0, 1'b0, 0);
            step(1'b1, 1'b1, v, c);
            k++;
        end while (!m_bnd);
    endtask

    // Monitor: compare each queued expectation just after the edge that produced it.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tph, int'(phase), e.ph);
            check(e.trs, int'(rs), int'(e.rs));
            check(e.tsd, int'(sd), int'(e.sd));
        end
    end

    initial begin
        repeat (3) step(1'b0, 1'b1, 1'b1, 9);        // R1 reset state
        repeat (3) step(1'b1, 1'b0, 1'b1, 3);        // R2 hold, R9 quiet
        run_round(1'b1, 3, 0);                        // slot1 <= +3
        run_round(1'b1, -4, 2);                       // slot2 <= -4
        run_round(1'b0, 7, 0);                        // R6 slot0 <= 0
        run_round(1'b1, S, 0);                        // R4 apply +3, slot1 <= S
        run_round(1'b1, 9, 1);                        // R5 apply -4 -> 12, R8 skip
        run_round(1'b1, -16, 0);                      // R6 apply 0, slot0 <= -T
        run_round(1'b1, 15, 0);                       // R8 land on S, slot1 <= 15
        run_round(1'b1, 0, 0);                        // R8 apply 9, past S
        run_round(1'b1, 2, 0);                        // R5 apply -T -> 0
        run_round(1'b1, 1, 0);                        // apply 15 -> immediate wrap
        run_round(1'b1, 0, 0);
        run_round(1'b1, 0, 0);
        repeat (4) step(1'b1, 1'b1, 1'b0, 0);
        repeat (2) step(1'b0, 1'b1, 1'b1, 6);        // R1 mid-round reset clears slots
        run_round(1'b1, 6, 0);                        // R1 first three apply 0
        run_round(1'b1, 6, 0);
        run_round(1'b1, 6, 0);
        run_round(1'b1, 0, 0);                        // R4 now applies 6
        repeat (3) step(1'b1, 1'b1, 1'b0, 0);
        @(posedge clk); #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule